// File: doc/BRIEF.md
# Four-Way Address Signature Hash

This block turns one memory word address into the bit pattern that a transactional read or write set records. The address goes through four hash functions in parallel. Each hash produces an index of `IDX_W` bits. That index is decoded one-hot into its own segment of `2**IDX_W` bits. The four segments are joined into one signature vector with exactly four bits set, and a conflict detector downstream ORs this vector into a set and ANDs sets together.

The hash family is fixed at elaboration by the `MODE` parameter, which selects one of four variants:

- **Plain bit selection.** Address bits are used directly as the index.
- **H3.** Each index bit is the XOR parity of an address subset given by a mask parameter.
- **Paired fold.** Each index bit is an upper-half address bit XORed with a lower-half bit.
- **Paired fold with progressive trimming.** Hash `k` skips the lowest `k*DROP` address bits on its lower-half side.

Addresses enter on a valid/ready stream and signatures leave on another. Back-pressure rules:

- When `REG_OUT` is 1, one register stage sits between the two streams. `in_ready` is high whenever that stage is empty or its content is being taken in the same cycle. A word held with `out_ready` low stays unchanged until it is taken.
- When `REG_OUT` is 0, the path is combinational. `out_valid` follows `in_valid` and `in_ready` follows `out_ready` in the same cycle.

Top module: `addr_sig_hash`

## Requirements
- R1: `out_sig` is made of 4 segments of `2**IDX_W` bits. Segment k occupies bits `[k*2**IDX_W +: 2**IDX_W]` and has exactly one bit set, at the position equal to hash k's index.
- R2: In bit-selection mode (MODE 0), index bit j of hash k equals `in_addr[(k*IDX_W+j) mod ADDR_W]`.
- R3: In H3 mode (MODE 1), index bit j of hash k is the XOR of every `in_addr[i]` for which `H3_MASK[(k*IDX_W+j)*ADDR_W + i]` is 1.
- R4: In paired-fold mode (MODE 2), with `L = ADDR_W/2` and `H = ADDR_W-L`, index bit j of hash k equals `in_addr[(k*IDX_W+j) mod L] ^ in_addr[L + ((k*IDX_W+j+k) mod H)]`.
- R5: In trimmed-fold mode (MODE 3), index bit j of hash k equals `in_addr[k*DROP + (j mod (L-k*DROP))] ^ in_addr[L + ((k*IDX_W+j) mod H)]`. As a result, hashes 1 to 3 ignore address bit 0 when DROP is at least 1.
- R6: With `REG_OUT`=1, an address accepted at a clock edge (`in_valid` and `in_ready` both high) appears as `out_valid`=1 with its signature after that same edge.
- R7: With `REG_OUT`=1, while `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_sig` hold their values across the next edge, whatever the input does.
- R8: With `REG_OUT`=1, `in_ready` equals `!out_valid || out_ready`.
- R9: During and right after reset (`rst_n` low, active-low asynchronous), `out_valid` is 0, `out_sig` is all zeros and, with `REG_OUT`=1, `in_ready` is 1.
- R10: With `REG_OUT`=0, `out_sig` carries the hash of the current `in_addr` in the same cycle, `out_valid` equals `in_valid`, and `in_ready` equals `out_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Address word offered |
| in_ready | output | 1 | Block can take the offered address |
| in_addr | input | ADDR_W | Word address to hash |
| out_valid | output | 1 | Signature word available |
| out_ready | input | 1 | Consumer takes the signature |
| out_sig | output | 4*2**IDX_W | Signature pattern, one-hot per segment |

## Verification
Every mode is driven with the same set of address patterns:
- All zeros and all ones, which separate an XOR fold from plain selection: a fold maps both to index 0, while selection sends all ones to the top bit of each segment.
- Walking single ones, which show which address bit feeds which index bit and segment.
- Alternating patterns, which expose swapped upper and lower halves.
- Address pairs that differ only in bit 0, which show the trimming in the trimmed-fold mode: only segment 0 may move.

The registered variant is also held under back-pressure while its input changes, to tell a true hold apart from a stage that keeps capturing.

// File: rtl/sig_hash_pkg.sv
package sig_hash_pkg;

  localparam int NUM_HASH = 4;

  typedef enum logic [1:0] {
    HM_BITSEL = 2'd0,
    HM_H3     = 2'd1,
    HM_PBX    = 2'd2,
    HM_LEPBX  = 2'd3
  } hash_mode_e;

  // plain selection position for index bit j of hash k
  function automatic int bs_pos(int k, int j, int idx_w, int addr_w);
    return (k * idx_w + j) % addr_w;
  endfunction

  // paired fold: lower-half and upper-half bit positions
  function automatic int pbx_lo(int k, int j, int idx_w, int lo_w);
    return (k * idx_w + j) % lo_w;
  endfunction

  function automatic int pbx_hi(int k, int j, int idx_w, int lo_w, int hi_w);
    return lo_w + ((k * idx_w + j + k) % hi_w);
  endfunction

  // trimmed fold: hash k skips the lowest k*drop lower-half bits
  function automatic int le_lo(int k, int j, int drop, int lo_w);
    return k * drop + (j % (lo_w - k * drop));
  endfunction

  function automatic int le_hi(int k, int j, int idx_w, int lo_w, int hi_w);
    return lo_w + ((k * idx_w + j) % hi_w);
  endfunction

endpackage

// File: rtl/sig_hash_index.sv
module sig_hash_index
  import sig_hash_pkg::*;
#(
  parameter int         ADDR_W   = 16,
  parameter int         IDX_W    = 4,
  parameter hash_mode_e MODE     = HM_H3,
  parameter int         HASH_NUM = 0,
  parameter int         DROP     = 1,
  parameter logic [IDX_W*ADDR_W-1:0] MASK = '1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);

  localparam int LO_W = ADDR_W / 2;
  localparam int HI_W = ADDR_W - LO_W;

  for (genvar j = 0; j < IDX_W; j++) begin : g_bit
    if (MODE == HM_BITSEL) begin : g_bs
      localparam int P = bs_pos(HASH_NUM, j, IDX_W, ADDR_W);
      assign idx[j] = addr[P];
    end else if (MODE == HM_H3) begin : g_h3
      localparam logic [ADDR_W-1:0] ROW = MASK[j*ADDR_W +: ADDR_W];
      assign idx[j] = ^(addr & ROW);
    end else if (MODE == HM_PBX) begin : g_pbx
      localparam int PL = pbx_lo(HASH_NUM, j, IDX_W, LO_W);
      localparam int PH = pbx_hi(HASH_NUM, j, IDX_W, LO_W, HI_W);
      assign idx[j] = addr[PL] ^ addr[PH];
    end else begin : g_le
      localparam int PL = le_lo(HASH_NUM, j, DROP, LO_W);
      localparam int PH = le_hi(HASH_NUM, j, IDX_W, LO_W, HI_W);
      assign idx[j] = addr[PL] ^ addr[PH];
    end
  end

endmodule

// File: rtl/sig_onehot_dec.sv
module sig_onehot_dec #(
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0]       idx,
  output logic [(1<<IDX_W)-1:0]  seg
);

  localparam int SEG_W = 1 << IDX_W;

  for (genvar b = 0; b < SEG_W; b++) begin : g_dec
    assign seg[b] = (idx == IDX_W'(b));
  end

endmodule

// File: rtl/sig_out_stage.sv
module sig_out_stage #(
  parameter int DATA_W  = 64,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  if (REG_OUT) begin : g_reg
    logic              vld_q;
    logic [DATA_W-1:0] dat_q;

    assign in_ready = !vld_q || out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        dat_q <= '0;
      end else if (in_ready) begin
        vld_q <= in_valid;
        if (in_valid) dat_q <= in_data;
      end
    end

    assign out_valid = vld_q;
    assign out_data  = dat_q;
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = in_valid ? in_data : '0;
  end

endmodule

// File: rtl/addr_sig_hash.sv
module addr_sig_hash
  import sig_hash_pkg::*;
#(
  parameter int         ADDR_W  = 16,
  parameter int         IDX_W   = 4,
  parameter hash_mode_e MODE    = HM_H3,
  parameter int         DROP    = 1,
  parameter bit         REG_OUT = 1'b1,
  parameter logic [NUM_HASH*IDX_W*ADDR_W-1:0] H3_MASK =
    {(NUM_HASH*IDX_W*ADDR_W/32){32'h9E37_79B9}}
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  output logic                            in_ready,
  input  logic [ADDR_W-1:0]               in_addr,
  output logic                            out_valid,
  input  logic                            out_ready,
  output logic [NUM_HASH*(1<<IDX_W)-1:0]  out_sig
);

  localparam int SEG_W  = 1 << IDX_W;
  localparam int SIG_W  = NUM_HASH * SEG_W;
  localparam int MROW_W = IDX_W * ADDR_W;

  logic [SIG_W-1:0] comb_sig;

  for (genvar k = 0; k < NUM_HASH; k++) begin : g_hash
    logic [IDX_W-1:0] idx;

    sig_hash_index #(
      .ADDR_W  (ADDR_W),
      .IDX_W   (IDX_W),
      .MODE    (MODE),
      .HASH_NUM(k),
      .DROP    (DROP),
      .MASK    (H3_MASK[k*MROW_W +: MROW_W])
    ) u_idx (
      .addr(in_addr),
      .idx (idx)
    );

    sig_onehot_dec #(
      .IDX_W(IDX_W)
    ) u_dec (
      .idx(idx),
      .seg(comb_sig[k*SEG_W +: SEG_W])
    );
  end

  sig_out_stage #(
    .DATA_W (SIG_W),
    .REG_OUT(REG_OUT)
  ) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (comb_sig),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_sig)
  );

endmodule

// File: rtl/sig_hash_chk.sv
module sig_hash_chk #(
  parameter int IDX_W   = 4,
  parameter bit REG_OUT = 1'b1
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            in_valid,
  input logic                            in_ready,
  input logic                            out_valid,
  input logic                            out_ready,
  input logic [4*(1<<IDX_W)-1:0]         out_sig
);

  localparam int SEG_W = 1 << IDX_W;

  for (genvar k = 0; k < 4; k++) begin : g_seg
    // R1
    seg_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $countones(out_sig[k*SEG_W +: SEG_W]) == 1);
  end

  if (REG_OUT) begin : g_reg
    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_sig)));

    // R8
    empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);

    // R6
    accept_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);
  end else begin : g_comb
    // R10
    pass_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid == in_valid) && (in_ready == out_ready));
  end

endmodule

bind addr_sig_hash sig_hash_chk #(
  .IDX_W  (IDX_W),
  .REG_OUT(REG_OUT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_sig  (out_sig)
);

// File: tb/tb_addr_sig_hash.sv
module tb_addr_sig_hash;
  import sig_hash_pkg::*;

  localparam int AW    = 16;
  localparam int IW    = 4;
  localparam int SEGW  = 1 << IW;
  localparam int SIGW  = 4 * SEGW;
  localparam int DROPV = 1;
  localparam logic [4*IW*AW-1:0] BENCH_MASK = {8{32'h6B2D_F048}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [AW-1:0] in_addr = '0;

  logic in_ready, out_valid;
  logic [SIGW-1:0] out_sig;
  logic rb_ready, rb_valid, rp_ready, rp_valid, rl_ready, rl_valid;
  logic [SIGW-1:0] sig_bs, sig_pbx, sig_le;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  addr_sig_hash #(.ADDR_W(AW), .IDX_W(IW), .MODE(HM_H3), .DROP(DROPV),
                  .REG_OUT(1'b1), .H3_MASK(BENCH_MASK)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
    .out_sig(out_sig));

  addr_sig_hash #(.ADDR_W(AW), .IDX_W(IW), .MODE(HM_BITSEL), .DROP(DROPV),
                  .REG_OUT(1'b0), .H3_MASK(BENCH_MASK)) u_bs (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rb_ready),
    .in_addr(in_addr), .out_valid(rb_valid), .out_ready(out_ready),
    .out_sig(sig_bs));

  addr_sig_hash #(.ADDR_W(AW), .IDX_W(IW), .MODE(HM_PBX), .DROP(DROPV),
                  .REG_OUT(1'b0), .H3_MASK(BENCH_MASK)) u_pbx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rp_ready),
    .in_addr(in_addr), .out_valid(rp_valid), .out_ready(out_ready),
    .out_sig(sig_pbx));

  addr_sig_hash #(.ADDR_W(AW), .IDX_W(IW), .MODE(HM_LEPBX), .DROP(DROPV),
                  .REG_OUT(1'b0), .H3_MASK(BENCH_MASK)) u_le (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rl_ready),
    .in_addr(in_addr), .out_valid(rl_valid), .out_ready(out_ready),
    .out_sig(sig_le));

  // expected index straight from the requirement formulas
  function automatic int exp_idx(int mode, int k, logic [AW-1:0] a);
    int r = 0;
    int lo = AW / 2;
    int hi = AW - lo;
    for (int j = 0; j < IW; j++) begin
      logic b;
      case (mode)
        0: b = a[(k*IW + j) % AW];
        1: b = ^(a & BENCH_MASK[(k*IW + j)*AW +: AW]);
        2: b = a[(k*IW + j) % lo] ^ a[lo + ((k*IW + j + k) % hi)];
        default: b = a[k*DROPV + (j % (lo - k*DROPV))] ^ a[lo + ((k*IW + j) % hi)];
      endcase
      if (b) r = r | (1 << j);
    end
    return r;
  endfunction

  function automatic logic [SIGW-1:0] exp_sig(int mode, logic [AW-1:0] a);
    logic [SIGW-1:0] s = '0;
    for (int k = 0; k < 4; k++) s[k*SEGW + exp_idx(mode, k, a)] = 1'b1;
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [SIGW-1:0] act,
                     input logic [SIGW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R9 out_valid", SIGW'(out_valid), '0);
    chk(out_sig == '0, "R9 out_sig", out_sig, '0);
    chk(in_ready == 1'b1, "R9 in_ready", SIGW'(in_ready), SIGW'(1));
  endtask

  // combinational variants: check same cycle
  task automatic t_comb_mode(input int mode, input logic [AW-1:0] a, input string req);
    logic [SIGW-1:0] act;
    @(negedge clk);
    in_addr = a;
    in_valid = 1'b1;
    #1;
    act = (mode == 0) ? sig_bs : (mode == 2) ? sig_pbx : sig_le;
    chk(act == exp_sig(mode, a), req, act, exp_sig(mode, a));
  endtask

  task automatic t_comb_pass();
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b0;
    #1;
    chk(rb_valid == 1'b0 && rb_ready == 1'b0, "R10 valid/ready pass",
        SIGW'({rb_valid, rb_ready}), '0);
    in_valid = 1'b1;
    out_ready = 1'b1;
    #1;
    chk(rp_valid == 1'b1 && rp_ready == 1'b1, "R10 valid/ready pass",
        SIGW'({rp_valid, rp_ready}), SIGW'(3));
  endtask

  // trimmed fold: bit 0 can only move segment 0
  task automatic t_le_trim(input logic [AW-1:0] a);
    logic [SIGW-1:0] s0, s1;
    @(negedge clk); in_addr = a; in_valid = 1'b1; #1; s0 = sig_le;
    in_addr = a ^ AW'(1); #1; s1 = sig_le;
    chk(s0[SIGW-1:SEGW] == s1[SIGW-1:SEGW], "R5 bit0 ignored by hashes 1-3",
        s1, s0);
  endtask

  // registered H3 path, one word at a time
  task automatic t_h3_reg(input logic [AW-1:0] a);
    @(negedge clk);
    out_ready = 1'b1;
    in_addr = a;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R6 latency", SIGW'(out_valid), SIGW'(1));
    chk(out_sig == exp_sig(1, a), "R3 H3 signature", out_sig, exp_sig(1, a));
    chk($countones(out_sig) == 4, "R1 four bits set", out_sig, exp_sig(1, a));
  endtask

  task automatic t_backpressure(input logic [AW-1:0] a, input logic [AW-1:0] b);
    @(negedge clk);
    out_ready = 1'b0;
    in_addr = a;
    in_valid = 1'b1;
    @(negedge clk);
    chk(out_sig == exp_sig(1, a), "R6 captured", out_sig, exp_sig(1, a));
    chk(in_ready == 1'b0, "R8 ready low when full", SIGW'(in_ready), '0);
    in_addr = b;
    @(negedge clk);
    @(negedge clk);
    chk(out_valid == 1'b1 && out_sig == exp_sig(1, a), "R7 hold under stall",
        out_sig, exp_sig(1, a));
    out_ready = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R8 ready with out_ready", SIGW'(in_ready), SIGW'(1));
    @(negedge clk);
    chk(out_sig == exp_sig(1, b), "R7 next word after release", out_sig, exp_sig(1, b));
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R6 drained", SIGW'(out_valid), '0);
  endtask

  initial begin
    logic [AW-1:0] pats [6];
    pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hAAAA;
    pats[3] = 16'h5555; pats[4] = 16'h00FF; pats[5] = 16'h1234;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    foreach (pats[i]) t_comb_mode(0, pats[i], "R2 bit-select");
    for (int w = 0; w < AW; w++) t_comb_mode(0, AW'(1) << w, "R2 bit-select walk");
    foreach (pats[i]) t_comb_mode(2, pats[i], "R4 paired fold");
    for (int w = 0; w < AW; w++) t_comb_mode(2, AW'(1) << w, "R4 paired fold walk");
    foreach (pats[i]) t_comb_mode(3, pats[i], "R5 trimmed fold");
    for (int w = 0; w < AW; w++) t_comb_mode(3, AW'(1) << w, "R5 trimmed fold walk");
    t_le_trim(16'h0000);
    t_le_trim(16'hC3A4);
    t_comb_pass();
    foreach (pats[i]) t_h3_reg(pats[i]);
    for (int w = 0; w < AW; w++) t_h3_reg(AW'(1) << w);
    t_backpressure(16'h0F0F, 16'hBEEF);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule